// File: doc/BRIEF.md
# PCI Read Command Selector

A bus-master DMA engine starts each read transfer by presenting a Dword start address, a Dword count and a few attributes for one clock. This block classifies the transfer and answers, one clock later, with the 4-bit PCI bus command that the master should drive during the address phase. The possible answers are a plain Memory Read, a Memory Read Line or a Memory Read Multiple.

The choice depends on the cache mode settings and on how the transfer lines up with the programmed cache line. Memory Read Line is reserved for transfers that span more than one Dword and stay inside a single cache line. It also needs a valid cache line size that fits within the DMA burst length. Memory Read Multiple replaces Read Line when the read-multiple mode is on, and it is also used for transfers that run past a line boundary. Non-prefetchable opcode fetches always use a plain Memory Read. The block only selects the command. It does not take part in arbitration, address or data phases, or writes.

Top module: `pci_rdcmd_sel`

## Requirements
- R1: `cmd_valid` is high for exactly the one cycle that follows each cycle with `req_valid` high, and low otherwise. A synchronous reset (`rst_n` low at a clock edge) clears `cmd_valid` and sets `cmd_code` to Memory Read.
- R2: The command encodings are: Memory Read = 4'b0110, Memory Read Line = 4'b1110, Memory Read Multiple = 4'b1100. No other code is ever output.
- R3: When `cfg_cache_en` is 0, the output is always Memory Read.
- R4: Memory Read Line needs both `cfg_cls_en` and `cfg_rdline_en` set. If `cfg_cls_en` is 0, the output is Memory Read.
- R5: `cfg_line_dw` counts as legal only when it is 8, 16, 32, 64 or 128 and is no greater than `cfg_burst_dw`. With an illegal value, the output is Memory Read.
- R6: A transfer of zero or one Dword does not cross a Dword boundary. It always gets Memory Read.
- R7: A transfer crosses a cache line when its first Dword address (`req_dw_addr`) and its last Dword address (`req_dw_addr + req_dw_cnt - 1`) lie in different line-aligned blocks. A crossing transfer never gets Read Line. It gets Read Multiple when `cfg_rdmult_en` is set and the cache, line-size and legality conditions hold. Otherwise it gets Memory Read.
- R8: A request with `req_np_fetch` set always gets Memory Read.
- R9: When every Read Line condition holds and `cfg_rdmult_en` is also set, the output is Read Multiple. If `cfg_rdmult_en` is set but `cfg_rdline_en` is clear, a non-crossing transfer gets Memory Read.
- R10: A transfer with all Read Line conditions met and `cfg_rdmult_en` clear gets Memory Read Line.
- R11: `cmd_code` keeps its value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe marking a new read transfer |
| req_dw_addr | input | ADDR_W | Dword address of the first Dword |
| req_dw_cnt | input | CNT_W | Number of Dwords in the transfer |
| req_np_fetch | input | 1 | Transfer is a non-prefetchable opcode fetch |
| cfg_cache_en | input | 1 | Cache mode enable |
| cfg_cls_en | input | 1 | Cache line size enable |
| cfg_rdline_en | input | 1 | Read-line mode enable |
| cfg_rdmult_en | input | 1 | Read-multiple mode enable |
| cfg_line_dw | input | LEN_W | Programmed cache line size in Dwords |
| cfg_burst_dw | input | LEN_W | DMA burst length in Dwords |
| cmd_valid | output | 1 | One-cycle pulse: `cmd_code` belongs to the previous request |
| cmd_code | output | 4 | Selected PCI read command |

## Verification
Each command is due exactly one clock edge after the edge that samples its request strobe. The valid pulse lasts only that one cycle, and the code then holds until the next request. The bench changes inputs on the falling edge and reads outputs on the next falling edge. Every result is therefore read half a cycle after the single register that produces it. The bench also reads one more falling edge later, to confirm that the pulse has dropped and the code has held. For back-to-back requests, one result is read at each falling edge while the next request is already being driven.

// File: rtl/pci_rdcmd_pkg.sv
package pci_rdcmd_pkg;
   typedef enum logic [3:0] {
      CMD_MEM_RD      = 4'b0110,
      CMD_MEM_RD_LINE = 4'b1110,
      CMD_MEM_RD_MULT = 4'b1100
   } rdcmd_e;
endpackage

// File: rtl/pci_rdcmd_line_chk.sv
// Decides whether the programmed cache line size is usable for line-based commands.
module pci_rdcmd_line_chk #(
   parameter int LEN_W        = 8,
   parameter int MIN_LINE_LOG = 3,
   parameter int MAX_LINE_LOG = 7
) (
   input  logic [LEN_W-1:0] line_dw,
   input  logic [LEN_W-1:0] burst_dw,
   output logic             line_ok
);
   localparam int N_SIZES = MAX_LINE_LOG - MIN_LINE_LOG + 1;

   if (MAX_LINE_LOG >= LEN_W) begin : g_bad_width
      $error("pci_rdcmd_line_chk: LEN_W too narrow for MAX_LINE_LOG");
   end
   if (MIN_LINE_LOG > MAX_LINE_LOG) begin : g_bad_range
      $error("pci_rdcmd_line_chk: MIN_LINE_LOG above MAX_LINE_LOG");
   end

   logic [N_SIZES-1:0] size_hit;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      assign size_hit[g] = (line_dw == LEN_W'(1 << (g + MIN_LINE_LOG)));
   end

   assign line_ok = (|size_hit) && (line_dw <= burst_dw);
endmodule

// File: rtl/pci_rdcmd_span.sv
// Classifies the transfer footprint: more than one Dword, and crossing of a line.
module pci_rdcmd_span #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 9,
   parameter int LEN_W  = 8
) (
   input  logic [ADDR_W-1:0] first_dw,
   input  logic [CNT_W-1:0]  dw_cnt,
   input  logic [LEN_W-1:0]  line_dw,
   output logic              multi_dw,
   output logic              cross_line
);
   localparam int EXT_W = ADDR_W + 1;

   if (CNT_W > ADDR_W || LEN_W > ADDR_W) begin : g_bad_width
      $error("pci_rdcmd_span: count or line width exceeds address width");
   end

   logic [EXT_W-1:0] first_ext;
   logic [EXT_W-1:0] last_ext;
   logic [EXT_W-1:0] blk_mask;

   always_comb begin
      first_ext  = {1'b0, first_dw};
      multi_dw   = (dw_cnt > CNT_W'(1));
      last_ext   = first_ext + EXT_W'(dw_cnt) - EXT_W'(1);
      blk_mask   = ~(EXT_W'(line_dw) - EXT_W'(1));
      cross_line = multi_dw && (|((first_ext ^ last_ext) & blk_mask));
   end
endmodule

// File: rtl/pci_rdcmd_sel.sv
module pci_rdcmd_sel
   import pci_rdcmd_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int CNT_W        = 9,
   parameter int LEN_W        = 8,
   parameter int MIN_LINE_LOG = 3,
   parameter int MAX_LINE_LOG = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_dw_addr,
   input  logic [CNT_W-1:0]  req_dw_cnt,
   input  logic              req_np_fetch,
   input  logic              cfg_cache_en,
   input  logic              cfg_cls_en,
   input  logic              cfg_rdline_en,
   input  logic              cfg_rdmult_en,
   input  logic [LEN_W-1:0]  cfg_line_dw,
   input  logic [LEN_W-1:0]  cfg_burst_dw,
   output logic              cmd_valid,
   output logic [3:0]        cmd_code
);
   logic   line_ok;
   logic   multi_dw;
   logic   cross_line;
   logic   cache_gate;
   logic   line_cond;
   logic   mult_cross;
   rdcmd_e next_cmd;
   rdcmd_e cmd_q;

   pci_rdcmd_line_chk #(
      .LEN_W       (LEN_W),
      .MIN_LINE_LOG(MIN_LINE_LOG),
      .MAX_LINE_LOG(MAX_LINE_LOG)
   ) u_line_chk (
      .line_dw (cfg_line_dw),
      .burst_dw(cfg_burst_dw),
      .line_ok (line_ok)
   );

   pci_rdcmd_span #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W),
      .LEN_W (LEN_W)
   ) u_span (
      .first_dw  (req_dw_addr),
      .dw_cnt    (req_dw_cnt),
      .line_dw   (cfg_line_dw),
      .multi_dw  (multi_dw),
      .cross_line(cross_line)
   );

   always_comb begin
      cache_gate = cfg_cache_en && cfg_cls_en && line_ok && !req_np_fetch;
      line_cond  = cache_gate && cfg_rdline_en && multi_dw && !cross_line;
      mult_cross = cache_gate && cfg_rdmult_en && cross_line;
      if ((line_cond && cfg_rdmult_en) || mult_cross) begin
         next_cmd = CMD_MEM_RD_MULT;
      end else if (line_cond) begin
         next_cmd = CMD_MEM_RD_LINE;
      end else begin
         next_cmd = CMD_MEM_RD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_q     <= CMD_MEM_RD;
      end else begin
         cmd_valid <= req_valid;
         if (req_valid) begin
            cmd_q <= next_cmd;
         end
      end
   end

   assign cmd_code = cmd_q;
endmodule

// File: rtl/pci_rdcmd_sel_chk.sv
module pci_rdcmd_sel_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [CNT_W-1:0] req_dw_cnt,
   input logic             req_np_fetch,
   input logic             cfg_cache_en,
   input logic             cfg_cls_en,
   input logic             cmd_valid,
   input logic [3:0]       cmd_code
);
   a_r1_pulse_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> cmd_valid);
   a_r1_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !cmd_valid);
   a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_code == 4'b0110 || cmd_code == 4'b1110 || cmd_code == 4'b1100));
   a_r3_cache_off_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_cache_en) |=> cmd_code == 4'b0110);
   a_r4_cls_off_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_cls_en) |=> cmd_code == 4'b0110);
   a_r6_single_dword_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dw_cnt <= CNT_W'(1)) |=> cmd_code == 4'b0110);
   a_r8_np_fetch_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_np_fetch) |=> cmd_code == 4'b0110);
   a_r11_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(cmd_code));
endmodule

bind pci_rdcmd_sel pci_rdcmd_sel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_dw_cnt  (req_dw_cnt),
   .req_np_fetch(req_np_fetch),
   .cfg_cache_en(cfg_cache_en),
   .cfg_cls_en  (cfg_cls_en),
   .cmd_valid   (cmd_valid),
   .cmd_code    (cmd_code)
);

// File: tb/pci_rdcmd_sel_test.sv
module pci_rdcmd_sel_test;
   localparam logic [3:0] MR = 4'b0110;
   localparam logic [3:0] RL = 4'b1110;
   localparam logic [3:0] RM = 4'b1100;

   typedef struct packed {
      logic [31:0] addr;
      logic [8:0]  cnt;
      logic        np;
      logic        cache;
      logic        cls;
      logic        rl;
      logic        rm;
      logic [7:0]  line;
      logic [7:0]  burst;
      logic [3:0]  exp;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16,  8'd16,  RL, 8'd10}, // R10
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  RM, 8'd9},  // R9
      '{32'd0,   9'd4,   1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  MR, 8'd3},  // R3
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd16,  8'd16,  MR, 8'd4},  // R4
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd16,  8'd16,  MR, 8'd4},  // R4
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd12,  8'd16,  MR, 8'd5},  // R5
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd32,  8'd16,  MR, 8'd5},  // R5
      '{32'd256, 9'd100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd128, 8'd128, RL, 8'd5},  // R5
      '{32'd3,   9'd1,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  MR, 8'd6},  // R6
      '{32'd14,  9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16,  8'd16,  MR, 8'd7},  // R7
      '{32'd14,  9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  RM, 8'd7},  // R7
      '{32'd0,   9'd4,   1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16,  8'd16,  MR, 8'd8},  // R8
      '{32'd14,  9'd4,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  MR, 8'd8},  // R8
      '{32'd12,  9'd4,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16,  8'd16,  RL, 8'd7},  // R7
      '{32'd8,   9'd8,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd8,   8'd16,  RL, 8'd5},  // R5
      '{32'd0,   9'd4,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd16,  8'd16,  MR, 8'd9},  // R9
      '{32'd5,   9'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  8'd16,  MR, 8'd6}   // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_dw_addr = '0;
   logic [8:0]  req_dw_cnt = '0;
   logic        req_np_fetch = 1'b0;
   logic        cfg_cache_en = 1'b0;
   logic        cfg_cls_en = 1'b0;
   logic        cfg_rdline_en = 1'b0;
   logic        cfg_rdmult_en = 1'b0;
   logic [7:0]  cfg_line_dw = '0;
   logic [7:0]  cfg_burst_dw = '0;
   logic        cmd_valid;
   logic [3:0]  cmd_code;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   pci_rdcmd_sel uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_dw_addr  (req_dw_addr),
      .req_dw_cnt   (req_dw_cnt),
      .req_np_fetch (req_np_fetch),
      .cfg_cache_en (cfg_cache_en),
      .cfg_cls_en   (cfg_cls_en),
      .cfg_rdline_en(cfg_rdline_en),
      .cfg_rdmult_en(cfg_rdmult_en),
      .cfg_line_dw  (cfg_line_dw),
      .cfg_burst_dw (cfg_burst_dw),
      .cmd_valid    (cmd_valid),
      .cmd_code     (cmd_code)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      req_dw_addr   = v.addr;
      req_dw_cnt    = v.cnt;
      req_np_fetch  = v.np;
      cfg_cache_en  = v.cache;
      cfg_cls_en    = v.cls;
      cfg_rdline_en = v.rl;
      cfg_rdmult_en = v.rm;
      cfg_line_dw   = v.line;
      cfg_burst_dw  = v.burst;
      req_valid     = 1'b1;
   endtask

   initial begin
      #20000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset valid", {3'b0, cmd_valid}, 4'd0);
      check("R1 reset code", cmd_code, MR);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 code set is exercised through every vector below
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(negedge clk);
         req_valid = 1'b0;
         check($sformatf("R%0d vec%0d valid", VECS[i].rq, i), {3'b0, cmd_valid}, 4'd1);
         check($sformatf("R%0d vec%0d code", VECS[i].rq, i), cmd_code, VECS[i].exp);
         @(negedge clk);
         check($sformatf("R1 vec%0d pulse end", i), {3'b0, cmd_valid}, 4'd0);
         check($sformatf("R11 vec%0d hold", i), cmd_code, VECS[i].exp);
      end

      // R1 back-to-back requests give one pulse each
      apply(VECS[0]);
      @(negedge clk);
      apply(VECS[1]);
      check("R1 b2b first valid", {3'b0, cmd_valid}, 4'd1);
      check("R10 b2b first code", cmd_code, RL);
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 b2b second valid", {3'b0, cmd_valid}, 4'd1);
      check("R9 b2b second code", cmd_code, RM);
      // R11: no request, inputs change, code must hold
      apply(VECS[2]);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 idle hold", cmd_code, RM);
      check("R1 idle valid", {3'b0, cmd_valid}, 4'd0);

      // R1: synchronous reset clears a pending pulse and the code
      apply(VECS[0]);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears valid", {3'b0, cmd_valid}, 4'd0);
      check("R1 reset clears code", cmd_code, MR);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule